// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag and Request Logic

This block gathers the three interrupt events of a real-time clock (an alarm match, a periodic tick and the end of a timekeeping update) into one status byte that clears when the host reads it. It also drives an active-low interrupt request line. Each event arrives as a one-cycle pulse. Its flag latches whether or not the matching enable bit is set, so software may either poll the status byte or take the interrupt line.

The host holds a read strobe high for the length of a status read. While the strobe is high, the flag bits do not move. Any event that lands during the read, including one in its final cycle, goes into a holding bit. On the first clock edge after the strobe falls, every flag that was reported is cleared and the held events are posted as the new flags. An event that arrives on that same edge is also kept. The enable bits come in as a level from a control byte held elsewhere. The interrupt line and the summary bit of the status byte follow flags and enables without a register stage, so writing an enable over a flag that is already set raises the request at once.

Top module: `rtc_irq_top`

## Requirements
- R1: After synchronous reset, `status_o` reads 0x00 and `irq_n_o` is 1.
- R2: An event pulse sampled at a clock edge outside a read sets its flag from that edge on, whatever the enable. Flag positions in `status_o`: bit 6 periodic, bit 5 alarm, bit 4 update-ended. Bits 3:0 always read 0.
- R3: `irq_n_o` is 0 exactly when some source has both its flag and its enable set. Enable positions in `ctrl_i`: bit 6 periodic, bit 5 alarm, bit 4 update-ended. All other `ctrl_i` bits have no effect.
- R4: `status_o` bit 7 is 1 exactly when `irq_n_o` is 0.
- R5: A read (`rd_strobe_i` high for one or more cycles) clears every flag, and with it bit 7, on the first clock edge after the strobe falls, unless an event is posted on that edge.
- R6: While `rd_strobe_i` stays high, flag bits 6:4 of `status_o` do not change.
- R7: An event during a read, including in its final strobe cycle, is held and appears as a flag from the first edge after the strobe falls.
- R8: Raising an enable while its flag is already set drives `irq_n_o` low in the same cycle, before the next clock edge.
- R9: Any combination of one, two or three flags can be set at once, and all of them are reported together.
- R10: An event sampled on the clearing edge right after a read is not lost: its flag is set after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_alarm_i | input | 1 | One-cycle alarm event pulse |
| evt_periodic_i | input | 1 | One-cycle periodic event pulse |
| evt_update_i | input | 1 | One-cycle update-ended event pulse |
| ctrl_i | input | 8 | Control byte; bits 6:4 are the per-source enables |
| rd_strobe_i | input | 1 | High for the length of a status read |
| status_o | output | 8 | Status byte: summary, three flags, zero padding |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with its default byte layout: three sources, flags in bits 6:4 and enables in bits 6:4. This keeps every flag and enable combination within a few cycles of stimulus. That layout lets one scripted run cover several cases: reads that gather one, two and three events; an event landing on the last strobe cycle; an event landing on the clearing edge; and enables raised over flags that are already set. Control bits outside the enable field are driven high to show they have no effect on the request.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    localparam int NUM_SRC  = 3;
    localparam int BYTE_W   = 8;
    localparam int FLAG_LSB = 4;
    localparam int EN_LSB   = 4;
    localparam int PAD_W    = BYTE_W - 1 - NUM_SRC;

    // source index order matches ascending bit position
    localparam int SRC_UPDATE   = 0;
    localparam int SRC_ALARM    = 1;
    localparam int SRC_PERIODIC = 2;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef struct packed {
        logic              summary;
        src_vec_t          flags;
        logic [PAD_W-1:0]  pad;
    } status_t;

    function automatic status_t pack_status(input logic summary, input src_vec_t flags);
        status_t s;
        s.summary = summary;
        s.flags   = flags;
        s.pad     = '0;
        return s;
    endfunction

    function automatic src_vec_t pick_enables(input logic [BYTE_W-1:0] ctrl);
        return ctrl[EN_LSB +: NUM_SRC];
    endfunction

endpackage

// File: rtl/rtc_irq_read_track.sv
module rtc_irq_read_track (
    input  logic clk,
    input  logic rst,
    input  logic rd_strobe_i,
    output logic rd_active_o,
    output logic rd_done_o
);
    logic rd_q;

    always_ff @(posedge clk) begin
        if (rst) rd_q <= 1'b0;
        else     rd_q <= rd_strobe_i;
    end

    assign rd_active_o = rd_strobe_i;
    assign rd_done_o   = rd_q & ~rd_strobe_i;
endmodule

// File: rtl/rtc_irq_flag_cell.sv
module rtc_irq_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic evt_i,
    input  logic rd_active_i,
    input  logic rd_done_i,
    output logic flag_o
);
    logic flag_q;
    logic hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            hold_q <= 1'b0;
        end else if (rd_active_i) begin
            hold_q <= hold_q | evt_i;
        end else if (rd_done_i) begin
            flag_q <= hold_q | evt_i;
            hold_q <= 1'b0;
        end else begin
            flag_q <= flag_q | evt_i;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/rtc_irq_req.sv
module rtc_irq_req
    import rtc_irq_pkg::*;
(
    input  src_vec_t flags_i,
    input  src_vec_t enables_i,
    output logic     req_o
);
    assign req_o = |(flags_i & enables_i);
endmodule

// File: rtl/rtc_irq_top.sv
module rtc_irq_top
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_alarm_i,
    input  logic              evt_periodic_i,
    input  logic              evt_update_i,
    input  logic [BYTE_W-1:0] ctrl_i,
    input  logic              rd_strobe_i,
    output logic [BYTE_W-1:0] status_o,
    output logic              irq_n_o
);
    src_vec_t evt_vec;
    src_vec_t flag_vec;
    logic     rd_active;
    logic     rd_done;
    logic     req;

    always_comb begin
        evt_vec               = '0;
        evt_vec[SRC_UPDATE]   = evt_update_i;
        evt_vec[SRC_ALARM]    = evt_alarm_i;
        evt_vec[SRC_PERIODIC] = evt_periodic_i;
    end

    rtc_irq_read_track u_track (
        .clk         (clk),
        .rst         (rst),
        .rd_strobe_i (rd_strobe_i),
        .rd_active_o (rd_active),
        .rd_done_o   (rd_done)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        rtc_irq_flag_cell u_cell (
            .clk         (clk),
            .rst         (rst),
            .evt_i       (evt_vec[i]),
            .rd_active_i (rd_active),
            .rd_done_i   (rd_done),
            .flag_o      (flag_vec[i])
        );
    end

    rtc_irq_req u_req (
        .flags_i   (flag_vec),
        .enables_i (pick_enables(ctrl_i)),
        .req_o     (req)
    );

    assign status_o = pack_status(req, flag_vec);
    assign irq_n_o  = ~req;
endmodule

// File: rtl/rtc_irq_checker.sv
module rtc_irq_checker
    import rtc_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              evt_alarm_i,
    input logic              evt_periodic_i,
    input logic              evt_update_i,
    input logic [BYTE_W-1:0] ctrl_i,
    input logic              rd_strobe_i,
    input logic [BYTE_W-1:0] status_o,
    input logic              irq_n_o
);
    logic prev_rd;
    logic armed;
    logic evt_in_read;
    logic evt_any;

    assign evt_any = evt_alarm_i | evt_periodic_i | evt_update_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_rd     <= 1'b0;
            armed       <= 1'b0;
            evt_in_read <= 1'b0;
        end else begin
            prev_rd     <= rd_strobe_i;
            armed       <= 1'b1;
            evt_in_read <= rd_strobe_i ? (evt_in_read | evt_any) : 1'b0;
        end
    end

    // R2: alarm event outside a read sets bit 5
    p_alarm_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (evt_alarm_i && !rd_strobe_i && !prev_rd) |=> status_o[5]);

    // R3: flag with its enable pulls the line low
    p_enabled_flag_req_r3: assert property (@(posedge clk) disable iff (rst)
        (status_o[6] && ctrl_i[6]) |-> !irq_n_o);

    // R4: summary bit tracks the line
    p_summary_tracks_line_r4: assert property (@(posedge clk) disable iff (rst)
        status_o[7] == !irq_n_o);

    // R5: quiet read leaves no flags
    p_read_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (prev_rd && !rd_strobe_i && !evt_any && !evt_in_read) |=> (status_o[6:4] == 3'b000));

    // R6: flags frozen across strobe cycles
    p_frozen_in_read_r6: assert property (@(posedge clk) disable iff (rst)
        (armed && prev_rd && rd_strobe_i) |-> $stable(status_o[6:4]));

    // R10: event on the clearing edge survives
    p_clear_edge_event_r10: assert property (@(posedge clk) disable iff (rst)
        (prev_rd && !rd_strobe_i && evt_update_i) |=> status_o[4]);
endmodule

bind rtc_irq_top rtc_irq_checker u_chk (.*);

// File: tb/rtc_irq_top_test.sv
module rtc_irq_top_test;

    typedef struct {
        logic [7:0] status;
        logic       irq_n;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       evt_alarm_i = 1'b0;
    logic       evt_periodic_i = 1'b0;
    logic       evt_update_i = 1'b0;
    logic [7:0] ctrl_i = 8'h00;
    logic       rd_strobe_i = 1'b0;
    logic [7:0] status_o;
    logic       irq_n_o;

    int total = 0;
    int bad = 0;
    bit stim_done = 1'b0;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    rtc_irq_top uut (
        .clk            (clk),
        .rst            (rst),
        .evt_alarm_i    (evt_alarm_i),
        .evt_periodic_i (evt_periodic_i),
        .evt_update_i   (evt_update_i),
        .ctrl_i         (ctrl_i),
        .rd_strobe_i    (rd_strobe_i),
        .status_o       (status_o),
        .irq_n_o        (irq_n_o)
    );

    // driver: apply one cycle of stimulus, queue the result expected after the edge
    task automatic drive(input logic p, input logic a, input logic u,
                         input logic [7:0] ctrl, input logic rd,
                         input logic [7:0] exp_st, input logic exp_irq, input string tag);
        exp_t e;
        @(negedge clk);
        evt_periodic_i = p;
        evt_alarm_i    = a;
        evt_update_i   = u;
        ctrl_i         = ctrl;
        rd_strobe_i    = rd;
        e.status = exp_st;
        e.irq_n  = exp_irq;
        e.tag    = tag;
        sb_q.push_back(e);
    endtask

    // monitor: compare shortly after each edge
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            total++;
            if (status_o !== e.status || irq_n_o !== e.irq_n) begin
                bad++;
                $display("FAIL %s: status=%02h irq_n=%b expected status=%02h irq_n=%b",
                         e.tag, status_o, irq_n_o, e.status, e.irq_n);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        drive(0,0,0, 8'h00, 0, 8'h00, 1, "R1 reset state");
        drive(0,1,0, 8'h00, 0, 8'h20, 1, "R2 alarm flag without enable");
        drive(0,0,0, 8'h00, 0, 8'h20, 1, "R2 alarm flag held");
        drive(0,0,0, 8'h20, 0, 8'hA0, 0, "R8 enable over set flag");
        drive(1,0,0, 8'h20, 0, 8'hE0, 0, "R9 periodic joins alarm");
        drive(0,0,1, 8'h20, 0, 8'hF0, 0, "R9 three flags, R4 summary");
        drive(0,0,0, 8'h20, 1, 8'hF0, 0, "R6 read start stable");
        drive(1,0,0, 8'h20, 1, 8'hF0, 0, "R6 event mid-read held");
        drive(0,1,0, 8'h20, 1, 8'hF0, 0, "R7 event on last strobe cycle");
        drive(0,0,0, 8'h20, 0, 8'hE0, 0, "R5 clear and R7 posting");
        drive(0,0,0, 8'h00, 0, 8'h60, 1, "R3 disable releases line");
        drive(0,0,0, 8'h00, 1, 8'h60, 1, "R6 second read stable");
        drive(0,0,1, 8'h00, 0, 8'h10, 1, "R10 event on clearing edge");
        drive(0,0,0, 8'h10, 0, 8'h90, 0, "R8 update enable immediate");
        drive(0,0,0, 8'h40, 0, 8'h10, 1, "R3 other enable no request");
        drive(0,0,0, 8'h40, 1, 8'h10, 1, "R6 third read");
        drive(0,0,0, 8'h40, 0, 8'h00, 1, "R5 read clears flag");
        drive(0,0,0, 8'h70, 0, 8'h00, 1, "R3 enables without flags");
        drive(1,0,0, 8'h70, 0, 8'hC0, 0, "R3 periodic request");
        drive(1,1,1, 8'h70, 1, 8'hC0, 0, "R7 three events in read held");
        drive(0,0,0, 8'h70, 0, 8'hF0, 0, "R7 R9 all three posted");
        drive(0,0,0, 8'h8F, 0, 8'h70, 1, "R3 non-enable ctrl bits ignored");
        drive(0,0,0, 8'h8F, 1, 8'h70, 1, "R6 fourth read");
        drive(0,0,0, 8'h8F, 1, 8'h70, 1, "R6 fourth read second cycle");
        drive(0,0,0, 8'h8F, 0, 8'h00, 1, "R5 multi-cycle read clears");
        drive(0,0,0, 8'h00, 0, 8'h00, 1, "R2 low bits zero idle");
        repeat (3) @(negedge clk);
        stim_done = 1'b1;
    end

    initial begin
        int cycles = 0;
        while (!stim_done && cycles < 2000) begin
            @(posedge clk);
            cycles++;
        end
        if (!stim_done) begin
            total++;
            bad++;
            $display("FAIL watchdog: stimulus hung, expected completion");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule